// File: doc/BRIEF.md
# Multi-channel auto-reload PWM timer

This block produces up to four pulse-width-modulated outputs from one shared 8-bit up-counter. The counter is clocked through a power-of-two prescaler whose source is either the core clock or an external frequency input. When the counter passes 255 it restarts from a programmable reload value, not from zero. The PWM period is therefore (256 − reload) counter ticks, and the duty resolution is one tick in that period.

Each channel holds its own compare value. Software never writes the compare value directly. It writes a duty register, and that value is copied into the compare stage only when the counter overflows, so a period in progress is never cut short or stretched. A channel is in its pulse phase from the overflow until the counter reaches the compare value. It produces a pulse only when its compare value is above the reload value. Every overflow sets a sticky flag, which can raise an interrupt request to act as a time base for software. For example, software can step the duty values through a sine table every few periods and filter the pin externally.

Software reaches every setting through a plain single-cycle register port. Writes land on the rising edge. Reads are combinational from the address. There is no data stream through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset the counter reads 0, the flag reads 0, irq_o is 0, and every pwm_o and pwm_drive_o bit is 0.
- R2: The control register at address 0x0 holds the following fields:
  - bit0: run
  - bit1: source select, where 0 is the core clock
  - bits4:2: tap n
  - bit5: interrupt enable

  While running, the counter advances once per 2^n pulses of the selected source.
- R3: With source select set to 1, each rising edge of ext_clk_i is one source pulse. The edge reaches the prescaler after a two-flop synchronizer and edge detector, and a steady input advances nothing.
- R4: While the run bit is 0, the counter and the prescaler hold their values.
- R5: On a tick while the counter holds 255, the counter loads the reload register (address 0x2) and an overflow occurs.
- R6: Address 0x3 reads the live counter and writes it at any time. A write wins over a tick in the same cycle. A write of 255 causes no overflow by itself.
- R7: Duty register k sits at address 0x8+k. Its value takes effect only at the next overflow, and a write in mid-period does not change the period in progress.
- R8: After an overflow, a channel is in its pulse phase for (duty − reload) ticks when duty > reload. It has no pulse phase when duty ≤ reload. The period is (256 − reload) ticks.
- R9: Address 0x4 holds the channel configuration:
  - bits3:0: output enable per channel
  - bits7:4: polarity per channel

  During the pulse phase an enabled pin shows its polarity bit, and it shows the inverse otherwise.
- R10: A channel with its output-enable bit at 0 has pwm_drive_o and pwm_o both 0.
- R11: Bit0 of address 0x1 is the overflow flag. Every overflow sets it. It clears only when software writes 1 to that bit, and writing 0 leaves it set. irq_o is the flag ANDed with the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | External count source, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| pwm_o | output | 4 | PWM pin levels |
| pwm_drive_o | output | 4 | Per-pin drive enable |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Timing of results:
- A register write is visible on reg_rdata_o at the next falling edge.
- A counter write shows its value at that same falling edge, even while a tick arrives.
- A tick at the core rate moves the counter one edge after the run bit is captured.

The bench therefore compares counter values across a known number of edges, as a function of the value first read, rather than at absolute times. Duty changes are checked only after two observed overflows, because the compare stage loads at overflow. Pulse widths are measured over a window of exactly one period in core cycles. That makes the high-cycle count independent of where the window starts.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam logic [3:0] A_CTRL   = 4'h0;
  localparam logic [3:0] A_STAT   = 4'h1;
  localparam logic [3:0] A_RELOAD = 4'h2;
  localparam logic [3:0] A_COUNT  = 4'h3;
  localparam logic [3:0] A_CHCFG  = 4'h4;
  localparam logic [3:0] A_DUTY0  = 4'h8;
  localparam int B_RUN   = 0;
  localparam int B_EXT   = 1;
  localparam int B_TAP   = 2;
  localparam int B_IRQEN = 5;
endpackage

// File: rtl/pwmt_prescale.sv
module pwmt_prescale #(
  parameter int DIVW = 7,
  localparam int TAPW = $clog2(DIVW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            src_ext,
  input  logic            ext_i,
  input  logic [TAPW-1:0] tap,
  output logic            tick
);
  logic [2:0]      sync_q;
  logic [DIVW-1:0] div_q;
  logic [DIVW-1:0] mask;
  logic            ext_rise;
  logic            src_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_i};
  end

  assign ext_rise  = sync_q[1] & ~sync_q[2];
  assign src_pulse = src_ext ? ext_rise : 1'b1;
  assign mask      = ~({DIVW{1'b1}} << tap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (run && src_pulse) div_q <= div_q + 1'b1;
  end

  assign tick = run & src_pulse & ((div_q & mask) == mask);

  // R4
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(div_q));
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d,
  output logic          ovf
);
  localparam logic [CW-1:0] TOP = '1;

  assign ovf = tick & ~wr & (cnt_q == TOP);

  always_comb begin
    if (wr)        cnt_d = wdata;
    else if (ovf)  cnt_d = reload;
    else if (tick) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cnt_q == $past(wdata));
  // R5
  ovf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt_q == $past(reload));
  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr) |=> $stable(cnt_q));
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ovf,
  input  logic [CW-1:0] duty,
  input  logic [CW-1:0] reload,
  input  logic [CW-1:0] cnt_d,
  input  logic          oe,
  input  logic          pol,
  output logic          pin,
  output logic          drive
);
  logic [CW-1:0] cmp_q;
  logic          act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      act_q <= 1'b0;
    end else if (ovf) begin
      cmp_q <= duty;
      act_q <= duty > reload;
    end else if (cnt_d == cmp_q) begin
      act_q <= 1'b0;
    end
  end

  assign drive = oe;
  assign pin   = oe & (act_q ? pol : ~pol);

  // R7
  cmp_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |=> $stable(cmp_q));
  // R8
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && cnt_d == cmp_q) |=> !act_q);
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
  import pwmt_pkg::*;
#(
  parameter int CW   = 8,
  parameter int NCH  = 4,
  parameter int DIVW = 7,
  localparam int TAPW = $clog2(DIVW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ext_clk_i,
  input  logic           reg_wr_i,
  input  logic [3:0]     reg_addr_i,
  input  logic [CW-1:0]  reg_wdata_i,
  output logic [CW-1:0]  reg_rdata_o,
  output logic [NCH-1:0] pwm_o,
  output logic [NCH-1:0] pwm_drive_o,
  output logic           irq_o
);
  logic [CW-1:0] ctrl_q, reload_q, chcfg_q;
  logic [CW-1:0] duty_q [NCH];
  logic          flag_q;
  logic          tick, ovf, cnt_wr;
  logic [CW-1:0] cnt_q, cnt_d;

  assign cnt_wr = reg_wr_i && (reg_addr_i == A_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      chcfg_q  <= '0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == A_CTRL)   ctrl_q   <= reg_wdata_i;
      if (reg_addr_i == A_RELOAD) reload_q <= reg_wdata_i;
      if (reg_addr_i == A_CHCFG)  chcfg_q  <= reg_wdata_i;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_duty
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) duty_q[g] <= '0;
      else if (reg_wr_i && reg_addr_i == 4'(int'(A_DUTY0) + g))
        duty_q[g] <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (ovf) flag_q <= 1'b1;
    else if (reg_wr_i && reg_addr_i == A_STAT && reg_wdata_i[0]) flag_q <= 1'b0;
  end

  assign irq_o = flag_q & ctrl_q[B_IRQEN];

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:   reg_rdata_o = ctrl_q;
      A_STAT:   reg_rdata_o = {{(CW-1){1'b0}}, flag_q};
      A_RELOAD: reg_rdata_o = reload_q;
      A_COUNT:  reg_rdata_o = cnt_q;
      A_CHCFG:  reg_rdata_o = chcfg_q;
      default: begin
        for (int i = 0; i < NCH; i++)
          if (reg_addr_i == 4'(int'(A_DUTY0) + i)) reg_rdata_o = duty_q[i];
      end
    endcase
  end

  pwmt_prescale #(.DIVW(DIVW)) presc_i (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[B_RUN]), .src_ext(ctrl_q[B_EXT]),
    .ext_i(ext_clk_i), .tap(ctrl_q[B_TAP +: TAPW]), .tick(tick)
  );

  pwmt_counter #(.CW(CW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr(cnt_wr), .wdata(reg_wdata_i),
    .reload(reload_q), .cnt_q(cnt_q), .cnt_d(cnt_d), .ovf(ovf)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwmt_channel #(.CW(CW)) ch_i (
      .clk(clk), .rst_n(rst_n), .ovf(ovf), .duty(duty_q[g]), .reload(reload_q),
      .cnt_d(cnt_d), .oe(chcfg_q[g]), .pol(chcfg_q[NCH + g]),
      .pin(pwm_o[g]), .drive(pwm_drive_o[g])
    );
  end

  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag_q);
endmodule

// File: tb/pwm_reload_timer_tb.sv
module pwm_reload_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [3:0] pwm, drv;
  logic       irq;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pwm_reload_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .pwm_o(pwm), .pwm_drive_o(drv), .irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0;
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] steps(logic [7:0] v, logic [7:0] rl, int n);
    logic [7:0] x = v;
    for (int i = 0; i < n; i++) x = (x == 8'hFF) ? rl : x + 8'd1;
    return x;
  endfunction

  task automatic wait_ovf();
    logic [7:0] s;
    for (int k = 0; k < 2; k++) begin
      wr(4'h1, 8'h01);
      do rd(4'h1, s); while (!s[0]);
    end
  endtask

  task automatic measure(int n, output int hi [4]);
    for (int c = 0; c < 4; c++) hi[c] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) if (pwm[c]) hi[c]++;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v1, v2, s;
    int hi [4];
    int duty [4];
    int pol [4];
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'h3, v1); chk("R1 count", v1, 0);
    rd(4'h1, v1); chk("R1 flag", v1, 0);
    chk("R1 pwm", pwm, 0); chk("R1 drive", drv, 0); chk("R1 irq", irq, 0);

    // R6 read/write while stopped, 255 does not overflow
    wr(4'h3, 8'h5A); rd(4'h3, v1); chk("R6 rw", v1, 8'h5A);
    wr(4'h2, 8'd200); wr(4'h3, 8'hFF);
    repeat (3) @(negedge clk);
    rd(4'h1, v1); chk("R6 no ovf on write", v1, 0);
    rd(4'h3, v1); chk("R6 holds 255", v1, 255);

    // R5 single tick from 255 reloads; R11 flag/irq
    wr(4'h0, 8'h21); wr(4'h0, 8'h20);
    rd(4'h3, v1); chk("R5 reload", v1, 200);
    rd(4'h1, v1); chk("R11 flag set", v1, 1);
    chk("R11 irq", irq, 1);
    wr(4'h1, 8'h00); rd(4'h1, v1); chk("R11 write0 keeps", v1, 1);
    wr(4'h0, 8'h00); chk("R11 irq masked", irq, 0);
    wr(4'h1, 8'h01); rd(4'h1, v1); chk("R11 clear", v1, 0);

    // R2 core clock, tap 0
    wr(4'h3, 8'd250); wr(4'h0, 8'h01);
    rd(4'h3, v1); repeat (9) @(negedge clk); rd(4'h3, v2);
    chk("R2 tap0 wrap", v2, steps(v1, 8'd200, 10));

    // R6 write wins over tick
    wr(4'h3, 8'd50); rd(4'h3, v1); chk("R6 write priority", v1, 50);

    // R2 tap 2
    wr(4'h0, 8'h09);
    rd(4'h3, v1); repeat (7) @(negedge clk); rd(4'h3, v2);
    chk("R2 tap2", v2, steps(v1, 8'd200, 2));
    rd(4'h3, v1); repeat (31) @(negedge clk); rd(4'h3, v2);
    chk("R2 tap2 long", v2, steps(v1, 8'd200, 8));

    // R4 hold
    wr(4'h0, 8'h08);
    rd(4'h3, v1); repeat (20) @(negedge clk); rd(4'h3, v2);
    chk("R4 hold", v2, v1);

    // R3 external source
    wr(4'h2, 8'd0); wr(4'h3, 8'd0); wr(4'h0, 8'h03);
    repeat (4) @(negedge clk);
    rd(4'h3, v1);
    for (int p = 0; p < 8; p++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    rd(4'h3, v2); chk("R3 ext edges", v2, steps(v1, 8'd0, 8));
    repeat (10) @(negedge clk);
    rd(4'h3, v1); chk("R3 steady ext", v1, v2);

    // R8 R9 widths with reload 100
    wr(4'h0, 8'h00); wr(4'h2, 8'd100);
    wr(4'h8, 8'd150); wr(4'h9, 8'd100); wr(4'hA, 8'd101); wr(4'hB, 8'd255);
    wr(4'h4, 8'h7F); wr(4'h0, 8'h01);
    wait_ovf();
    measure(156, hi);
    chk("R8 ch0 width", hi[0], 50);
    chk("R8 duty==reload none", hi[1], 0);
    chk("R8 min width", hi[2], 1);
    chk("R9 inverted polarity", hi[3], 1);
    chk("R10 drive on", drv, 4'hF);

    // R10 output disable
    wr(4'h4, 8'h7E);
    measure(156, hi);
    chk("R10 pin off", hi[0], 0); chk("R10 drive off", drv[0], 0);

    // R7 double buffering
    wr(4'h4, 8'h11); wr(4'h2, 8'd0); wr(4'h8, 8'd192);
    wait_ovf();
    do rd(4'h3, v1); while (!(v1 >= 100 && v1 < 140));
    wr(4'h8, 8'd120);
    do rd(4'h3, v1); while (!(v1 >= 150 && v1 < 180));
    chk("R7 old duty holds", pwm[0], 1);
    wait_ovf();
    measure(256, hi);
    chk("R7 new duty", hi[0], 120);

    // R8 R9 random trials
    for (int t = 0; t < 8; t++) begin
      int rl, tp, per;
      logic [7:0] cfg;
      rl = $urandom_range(0, 200);
      tp = $urandom_range(0, 2);
      cfg = 8'h0F;
      for (int c = 0; c < 4; c++) begin
        duty[c] = $urandom_range(0, 255);
        pol[c] = $urandom_range(0, 1);
        cfg[4 + c] = pol[c][0];
        wr(4'(8 + c), 8'(duty[c]));
      end
      wr(4'h2, 8'(rl)); wr(4'h4, cfg); wr(4'h0, 8'(1 + (tp << 2)));
      wait_ovf();
      per = (256 - rl) << tp;
      measure(per, hi);
      for (int c = 0; c < 4; c++) begin
        int pc;
        pc = (duty[c] > rl) ? ((duty[c] - rl) << tp) : 0;
        chk("R8 R9 random", hi[c], pol[c] ? pc : per - pc);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule